// File: doc/BRIEF.md
# DMA Channel Controller

A single programmable DMA channel. A host configures it through a small word-addressed register port and then lets it run. The channel moves a block of bytes on its own by issuing read and write cycles on a simple bus-master port. Each cycle holds its request until the bus answers with an acknowledge or an error. The host sees a level interrupt when the block is finished.

There are two transfer modes. In dual-address mode each unit of work reads from the source address and then writes the data to the destination address. A 32-bit holding word packs or unpacks operands when the two sizes differ. In single-address mode only one address goes out per cycle and no data passes through the channel. A direction bit picks a read at the source address or a write at the destination address. Work is paced by one of three request modes:
- internal, which runs back to back;
- external burst, which runs while a request line is high;
- external cycle-steal, which does one unit per rising edge of that line.

Five sticky status flags record how the channel stopped. None of them clears itself. A start is refused while any of them is set, so the host must acknowledge the previous outcome before it can run the channel again.

Top module: `dma_channel`

## Requirements
- R1: After reset every register reads zero, `bus_req` is low and `irq` is low. Register offsets are: 0 control, 1 status, 2 function code, 3 source address, 4 destination address, 5 byte count.
- R2: A transfer begins only on a control write, made while idle, whose bit 0 (start) is 1 and while all status flags are clear. A control write with start 0, or one made while any flag is set, issues no bus cycle. Status bit 0 reads 1 while the channel is active.
- R3: A start attempt with all flags clear sets CONF (status bit 3) and does not start when any of these holds:
  - the byte count is zero;
  - the byte count is not a multiple of the transfer unit;
  - a size or request field holds 11;
  - internal request is chosen in single-address mode.
  The transfer unit is the larger of the two sizes in dual-address mode, and the size in use in single-address mode.
- R4: The control bit fields are: [1] single-address mode, [6:5] source size, [8:7] destination size. Sizes are encoded 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes. In dual-address mode each unit issues unit/source-size reads at the source address and then unit/destination-size writes at the destination address. Operand bytes are packed low byte first, and the write data in the low bits of `bus_wdata` carries the bytes read, in order.
- R5: The source address advances by the source size after each read only when control bit 3 is set. The destination address advances by the destination size after each write only when control bit 4 is set.
- R6: In single-address mode, control bit 2 = 0 issues reads at the source address with the source size. Control bit 2 = 1 issues writes at the destination address with the destination size.
- R7: The byte count drops by the size of each completed single-address cycle or dual-address write. When it reaches zero, the channel sets DONE (status bit 6) and goes idle. `irq` is high while DONE is set and control bit 11 is 1.
- R8: With request field [10:9] = 01 (burst), a new unit starts only while `dreq` is high.
- R9: With request field 10 (cycle-steal), exactly one unit runs per rising edge of `dreq` seen while the channel is active. Field 00 selects internal request.
- R10: `bus_err` ending a read sets BES (status bit 5). Ending a write, it sets BED (status bit 4). In both cases the channel stops without setting DONE.
- R11: Writing ones to status bits 6:2 clears the matching flags and leaves the others. Writing 0x7C clears them all.
- R12: A `bkpt` pulse sets BRKP (status bit 2). The channel issues no further unit and goes idle.
- R13: A bus cycle keeps address, direction and size stable until acknowledged. `bus_fc` carries function-code register bits [3:0] on reads and bits [7:4] on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | External transfer request |
| bkpt | input | 1 | Breakpoint pulse |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | 1 = write cycle |
| bus_addr | output | AW | Cycle address |
| bus_size | output | 2 | Operand size code |
| bus_fc | output | 4 | Function code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Cycle completed |
| bus_err | input | 1 | Cycle ended in error |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is cycle-steal pacing. There, a unit must follow each rising edge of `dreq` exactly once, even when the line stays high for longer than a unit takes. The stimulus first starts the channel and then pulses `dreq`, holding it high for several cycles past the end of each unit. After every pulse it checks that exactly one more bus cycle has appeared. Bus errors are injected by the responder on a chosen cycle index, so the first read and the first write can each be made to fail. Breakpoints are driven while the channel sits waiting for a request, which makes their outcome predictable.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dreq,
  input  logic          bkpt,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [3:0]    bus_fc,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          irq
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_FC = 3'd2,
                         A_SRC = 3'd3, A_DST = 3'd4, A_CNT = 3'd5;
  localparam int F_DONE = 4, F_BES = 3, F_BED = 2, F_CONF = 1, F_BRKP = 0;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} st_t;

  function automatic logic [2:0] nbytes(input logic [1:0] c);
    case (c)
      2'b00:   return 3'd4;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] unit_of(input logic [11:0] c);
    logic [2:0] s, d;
    s = nbytes(c[6:5]);
    d = nbytes(c[8:7]);
    if (c[1]) return c[2] ? d : s;
    if (s == 3'd0 || d == 3'd0) return 3'd0;
    return (s > d) ? s : d;
  endfunction

  logic [11:0]   ctrl;
  logic [4:0]    flags;
  logic [7:0]    fc;
  logic [AW-1:0] sar, dar;
  logic [CW-1:0] btc;
  st_t           st;
  logic [1:0]    beat;
  logic [31:0]   hold;
  logic          dreq_q, pend;

  wire       single = ctrl[1];
  wire       dir    = ctrl[2];
  wire [1:0] ssz    = ctrl[6:5];
  wire [1:0] dsz    = ctrl[8:7];
  wire [1:0] rqm    = ctrl[10:9];
  wire [2:0] ssb    = nbytes(ssz);
  wire [2:0] dsb    = nbytes(dsz);
  wire [2:0] unit   = unit_of(ctrl);
  wire [2:0] rd_beats = (ssb == 3'd4) ? 3'd1 : (ssb == 3'd2) ? (unit >> 1) : unit;
  wire [2:0] wr_beats = (dsb == 3'd4) ? 3'd1 : (dsb == 3'd2) ? (unit >> 1) : unit;
  wire       last_rd  = ({1'b0, beat} + 3'd1) == rd_beats;
  wire       last_wr  = ({1'b0, beat} + 3'd1) == wr_beats;
  wire [4:0] rd_off   = 5'(beat) * 5'(ssb);
  wire [4:0] wr_off   = 5'(beat) * 5'(dsb);
  wire [31:0] rmask   = (ssb == 3'd1) ? 32'h0000_00FF :
                        (ssb == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  wire       host_idle = (st == S_IDLE);
  wire [2:0] n_unit    = unit_of(reg_wdata[11:0]);
  wire [1:0] n_rqm     = reg_wdata[10:9];
  wire       cfg_bad   = (btc == '0) || (n_unit == 3'd0) ||
                         ((btc & CW'(n_unit - 3'd1)) != '0) || (n_rqm == 2'b11) ||
                         (reg_wdata[1] && n_rqm == 2'b00);
  wire       start_try = reg_we && reg_addr == A_CTRL && host_idle && reg_wdata[0];
  wire       start_ok  = start_try && flags == '0 && !cfg_bad;

  wire rise    = dreq & ~dreq_q;
  wire go      = (rqm == 2'b00) ? 1'b1 : (rqm == 2'b01) ? dreq : pend;
  wire take    = (st == S_WAIT) && !flags[F_BRKP] && go;
  wire consume = take && rqm == 2'b10;

  wire rd_cycle = (st == S_RD);
  wire wr_cycle = (st == S_WR);
  wire ok_ack   = bus_ack && !bus_err;
  wire done_hit = btc == CW'(wr_cycle ? dsb : ssb);

  assign bus_req   = rd_cycle | wr_cycle;
  assign bus_wr    = wr_cycle;
  assign bus_addr  = wr_cycle ? dar : sar;
  assign bus_size  = wr_cycle ? dsz : ssz;
  assign bus_fc    = wr_cycle ? fc[7:4] : fc[3:0];
  assign bus_wdata = (wr_cycle && !single) ? (hold >> {wr_off, 3'b000}) : 32'h0;
  assign irq       = ctrl[11] & flags[F_DONE];

  logic [4:0] fl_set, fl_clr;
  always_comb begin
    fl_clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[6:2] : 5'h0;
    fl_set = 5'h0;
    fl_set[F_CONF] = start_try && flags == '0 && cfg_bad;
    fl_set[F_BRKP] = bkpt;
    fl_set[F_BES]  = rd_cycle && bus_err;
    fl_set[F_BED]  = wr_cycle && bus_err;
    fl_set[F_DONE] = ok_ack && done_hit && (wr_cycle || (rd_cycle && single));
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {20'h0, ctrl};
      A_STAT:  reg_rdata = {25'h0, flags, 1'b0, ~host_idle};
      A_FC:    reg_rdata = {24'h0, fc};
      A_SRC:   reg_rdata = 32'(sar);
      A_DST:   reg_rdata = 32'(dar);
      A_CNT:   reg_rdata = 32'(btc);
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; flags <= '0; fc <= '0; sar <= '0; dar <= '0; btc <= '0;
      st <= S_IDLE; beat <= '0; hold <= '0; dreq_q <= 1'b0; pend <= 1'b0;
    end else begin
      dreq_q <= dreq;
      pend   <= (pend & ~consume & ~start_ok) | (rise & ~host_idle);
      flags  <= (flags & ~fl_clr) | fl_set;
      if (reg_we && host_idle) begin
        case (reg_addr)
          A_CTRL:  ctrl <= reg_wdata[11:0];
          A_FC:    fc   <= reg_wdata[7:0];
          A_SRC:   sar  <= reg_wdata[AW-1:0];
          A_DST:   dar  <= reg_wdata[AW-1:0];
          A_CNT:   btc  <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (start_ok) begin st <= S_WAIT; beat <= '0; end
        S_WAIT: begin
          if (flags[F_BRKP]) st <= S_IDLE;
          else if (take) begin
            beat <= '0;
            hold <= '0;
            st   <= (single && dir) ? S_WR : S_RD;
          end
        end
        S_RD: begin
          if (bus_err) st <= S_IDLE;
          else if (bus_ack) begin
            if (ctrl[3]) sar <= sar + AW'(ssb);
            if (single) begin
              btc <= btc - CW'(ssb);
              st  <= done_hit ? S_IDLE : S_WAIT;
            end else begin
              hold <= hold | ((bus_rdata & rmask) << {rd_off, 3'b000});
              if (last_rd) begin st <= S_WR; beat <= '0; end
              else beat <= beat + 2'd1;
            end
          end
        end
        S_WR: begin
          if (bus_err) st <= S_IDLE;
          else if (bus_ack) begin
            if (ctrl[4]) dar <= dar + AW'(dsb);
            btc <= btc - CW'(dsb);
            if (done_hit) st <= S_IDLE;
            else if (single || last_wr) begin st <= S_WAIT; beat <= '0; end
            else beat <= beat + 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_size)));

  p_flag_blocks_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idle && reg_we && reg_addr == A_CTRL && reg_wdata[0] && flags != '0) |=>
      (st == S_IDLE));

  p_zero_count_conf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idle && reg_we && reg_addr == A_CTRL && reg_wdata[0] && flags == '0 && btc == '0) |=>
      (flags[F_CONF] && st == S_IDLE));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && ok_ack) |=> (btc == $past(btc) - CW'($past(dsb))));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_DONE]) |-> (st == S_IDLE));

  p_read_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_err) |=> (flags[F_BES] && !flags[F_DONE] && st == S_IDLE));
endmodule

// File: tb/tb_dma_channel.sv
`timescale 1ns/100ps
module tb_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        dreq = 1'b0, bkpt = 1'b0;
  logic        bus_req, bus_wr;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [3:0]  bus_fc;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = 32'h0;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  dma_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .bkpt(bkpt),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_fc(bus_fc), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq));

  integer n_tests = 0, n_fail = 0;
  integer cyc_seen = 0, err_at = -1, lat = 0, lat_cnt = 0;
  bit     finished = 1'b0;
  string  cur_req = "R4";
  logic [7:0] fc_reg = 8'h5A;
  logic [7:0] mem [256];

  logic        q_wr[$];
  logic [31:0] q_addr[$];
  logic [1:0]  q_size[$];
  logic [3:0]  q_fc[$];
  logic [31:0] q_data[$];
  logic [31:0] q_mask[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input int b);
    return (b == 4) ? 2'b00 : (b == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit start, input bit sgl, input bit dir,
      input bit si, input bit di, input int sb, input int db, input logic [1:0] rq, input bit ie);
    return {20'h0, ie, rq, enc(db), enc(sb), di, si, dir, sgl, start};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] w = 32'h0;
    int n = (sz == 2'b00) ? 4 : (sz == 2'b01) ? 1 : 2;
    for (int j = 0; j < n; j++) w[8*j +: 8] = mem[(a + 32'(j)) & 32'hFF];
    return w;
  endfunction

  task automatic push(input bit wr, input logic [31:0] a, input int b,
                      input logic [31:0] d, input logic [31:0] m);
    q_wr.push_back(wr); q_addr.push_back(a); q_size.push_back(enc(b));
    q_fc.push_back(wr ? fc_reg[7:4] : fc_reg[3:0]);
    q_data.push_back(d); q_mask.push_back(m);
  endtask

  task automatic model_dual(input logic [31:0] sa0, input logic [31:0] da0, input int sb,
                            input int db, input bit si, input bit di, input int cnt);
    logic [7:0]  bs[$];
    logic [31:0] sa = sa0, da = da0, d;
    int u = (sb > db) ? sb : db;
    for (int k = 0; k < cnt / u; k++) begin
      for (int r = 0; r < u / sb; r++) begin
        push(1'b0, sa, sb, 32'h0, 32'h0);
        for (int j = 0; j < sb; j++) bs.push_back(mem[(sa + 32'(j)) & 32'hFF]);
        if (si) sa += 32'(sb);
      end
      for (int w = 0; w < u / db; w++) begin
        d = 32'h0;
        for (int j = 0; j < db; j++) d[8*j +: 8] = bs.pop_front();
        push(1'b1, da, db, d, (db == 4) ? 32'hFFFF_FFFF : (db == 2) ? 32'hFFFF : 32'hFF);
        if (di) da += 32'(db);
      end
    end
  endtask

  task automatic model_single(input logic [31:0] a0, input int b, input bit dir,
                              input bit inc, input int cnt);
    logic [31:0] a = a0;
    for (int k = 0; k < cnt / b; k++) begin
      push(dir, a, b, 32'h0, 32'h0);
      if (inc) a += 32'(b);
    end
  endtask

  always @(negedge clk) begin
    if (bus_ack || bus_err) begin
      bus_ack = 1'b0; bus_err = 1'b0;
    end else if (bus_req) begin
      if (lat_cnt < lat) lat_cnt++;
      else begin
        lat_cnt = 0;
        if (q_wr.size() == 0) chk(1'b0, cur_req, "unexpected bus cycle addr", bus_addr, 32'h0);
        else begin
          chk(bus_addr == q_addr[0] && bus_wr == q_wr[0], cur_req, "cycle addr/dir",
              {bus_wr, bus_addr[30:0]}, {q_wr[0], q_addr[0][30:0]});
          chk(bus_size == q_size[0] && bus_fc == q_fc[0] &&
              ((bus_wdata & q_mask[0]) == q_data[0]), cur_req, "cycle size/fc/data",
              {bus_size, bus_fc, bus_wdata[25:0]}, {q_size[0], q_fc[0], q_data[0][25:0]});
          void'(q_wr.pop_front()); void'(q_addr.pop_front()); void'(q_size.pop_front());
          void'(q_fc.pop_front()); void'(q_data.pop_front()); void'(q_mask.pop_front());
        end
        if (!bus_wr) bus_rdata = rd_word(bus_addr, bus_size);
        if (cyc_seen == err_at) begin
          bus_err = 1'b1;
          q_wr.delete(); q_addr.delete(); q_size.delete();
          q_fc.delete(); q_data.delete(); q_mask.delete();
        end else bus_ack = 1'b1;
        cyc_seen++;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string req, input string what);
    logic [31:0] v;
    rd_reg(a, v);
    chk(v == e, req, what, v, e);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(3'd1, v);
      if (!v[0]) break;
    end
  endtask

  task automatic prep(input logic [31:0] s, input logic [31:0] d, input int cnt);
    cyc_seen = 0; err_at = -1;
    wr_reg(3'd3, s); wr_reg(3'd4, d); wr_reg(3'd5, 32'(cnt)); wr_reg(3'd2, {24'h0, fc_reg});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #750000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 6; a++) chk_reg(3'(a), 32'h0, "R1", "register after reset");
    chk(!bus_req && !irq, "R1", "bus_req/irq after reset", {bus_req, irq}, 32'h0);

    // R2: configure with start low, nothing runs
    cur_req = "R4";
    prep(32'h10, 32'h80, 8);
    wr_reg(3'd0, mk_ctrl(0, 0, 0, 1, 1, 4, 4, 2'b00, 1));
    repeat (6) @(negedge clk);
    chk(cyc_seen == 0, "R2", "cycles with start low", cyc_seen, 0);
    chk_reg(3'd1, 32'h0, "R2", "status with start low");
    // R4 R5 R7: dual long to long
    model_dual(32'h10, 32'h80, 4, 4, 1, 1, 8);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b00, 1));
    wait_idle();
    chk(q_wr.size() == 0 && cyc_seen == 4, "R4", "dual long cycles", cyc_seen, 4);
    chk_reg(3'd1, 32'h40, "R7", "DONE status");
    chk(irq == 1'b1, "R7", "irq enabled on DONE", irq, 1);
    chk_reg(3'd5, 32'h0, "R7", "count at end");
    chk_reg(3'd3, 32'h18, "R5", "source advanced");
    chk_reg(3'd4, 32'h88, "R5", "destination advanced");
    wr_reg(3'd1, 32'h7C);
    chk_reg(3'd1, 32'h0, "R11", "clear all");
    chk(irq == 1'b0, "R11", "irq after clear", irq, 0);

    // R4 R13: byte source packed into long writes, slow bus
    lat = 2; cur_req = "R13";
    prep(32'h21, 32'h90, 8);
    model_dual(32'h21, 32'h90, 1, 4, 1, 1, 8);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 1, 4, 2'b00, 0));
    wait_idle();
    chk(q_wr.size() == 0 && cyc_seen == 10, "R4", "pack cycles", cyc_seen, 10);
    chk(irq == 1'b0, "R7", "irq disabled", irq, 0);
    lat = 0;

    // R5: long source into word writes at a fixed destination
    wr_reg(3'd1, 32'h40);
    chk_reg(3'd1, 32'h0, "R11", "clear DONE only");
    cur_req = "R5";
    prep(32'h30, 32'hA0, 4);
    model_dual(32'h30, 32'hA0, 4, 2, 1, 0, 4);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 0, 4, 2, 2'b00, 0));
    wait_idle();
    chk(q_wr.size() == 0 && cyc_seen == 3, "R5", "unpack cycles", cyc_seen, 3);
    chk_reg(3'd4, 32'hA0, "R5", "destination held");
    wr_reg(3'd1, 32'h7C);

    // R8 R6: burst single-address reads
    cur_req = "R6";
    prep(32'h20, 32'hF0, 6);
    model_single(32'h20, 2, 0, 1, 6);
    wr_reg(3'd0, mk_ctrl(1, 1, 0, 1, 0, 2, 4, 2'b01, 0));
    repeat (20) @(negedge clk);
    chk(cyc_seen == 0, "R8", "no cycle while dreq low", cyc_seen, 0);
    dreq = 1'b1;
    wait_idle();
    dreq = 1'b0;
    chk(q_wr.size() == 0 && cyc_seen == 3, "R8", "burst cycles", cyc_seen, 3);
    chk_reg(3'd1, 32'h40, "R6", "single read DONE");
    wr_reg(3'd1, 32'h7C);

    // R9: cycle-steal single-address writes
    cur_req = "R9";
    prep(32'h00, 32'h40, 12);
    model_single(32'h40, 4, 1, 1, 12);
    wr_reg(3'd0, mk_ctrl(1, 1, 1, 0, 1, 1, 4, 2'b10, 0));
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); dreq = 1'b1;
      repeat (8) @(negedge clk); dreq = 1'b0;
      repeat (6) @(negedge clk);
      chk(cyc_seen == k, "R9", "one unit per edge", cyc_seen, k);
    end
    chk_reg(3'd1, 32'h40, "R9", "cycle-steal DONE");
    wr_reg(3'd1, 32'h7C);

    // R3 R2: configuration errors and blocked start
    prep(32'h10, 32'h80, 6);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b00, 0));
    chk_reg(3'd1, 32'h08, "R3", "count not multiple");
    wr_reg(3'd5, 32'd8);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b00, 0));
    repeat (8) @(negedge clk);
    chk(cyc_seen == 0, "R2", "start refused with flag set", cyc_seen, 0);
    chk_reg(3'd1, 32'h08, "R2", "still idle with CONF");
    wr_reg(3'd1, 32'h7C);
    wr_reg(3'd0, mk_ctrl(1, 1, 0, 1, 0, 4, 4, 2'b00, 0));
    chk_reg(3'd1, 32'h08, "R3", "internal request in single mode");
    wr_reg(3'd1, 32'h7C);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b11, 0));
    chk_reg(3'd1, 32'h08, "R3", "reserved request field");
    wr_reg(3'd1, 32'h7C);
    wr_reg(3'd5, 32'd0);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 1, 1, 2'b00, 0));
    chk_reg(3'd1, 32'h08, "R3", "zero count");
    chk(cyc_seen == 0, "R3", "no cycles on CONF", cyc_seen, 0);
    wr_reg(3'd1, 32'h7C);

    // R10: bus errors on read and on write
    cur_req = "R10";
    prep(32'h10, 32'h80, 8);
    err_at = 0;
    model_dual(32'h10, 32'h80, 4, 4, 1, 1, 8);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b00, 1));
    wait_idle();
    chk_reg(3'd1, 32'h20, "R10", "BES on read error");
    chk(cyc_seen == 1, "R10", "stop after read error", cyc_seen, 1);
    wr_reg(3'd1, 32'h7C);
    prep(32'h10, 32'h80, 8);
    err_at = 1;
    model_dual(32'h10, 32'h80, 4, 4, 1, 1, 8);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b00, 1));
    wait_idle();
    chk_reg(3'd1, 32'h10, "R10", "BED on write error");
    chk(cyc_seen == 2 && irq == 1'b0, "R10", "stop after write error", cyc_seen, 2);
    wr_reg(3'd1, 32'h7C);

    // R12: breakpoint while waiting for a request
    cur_req = "R12";
    prep(32'h10, 32'h80, 8);
    wr_reg(3'd0, mk_ctrl(1, 0, 0, 1, 1, 4, 4, 2'b10, 0));
    @(negedge clk); bkpt = 1'b1;
    @(negedge clk); bkpt = 1'b0;
    repeat (4) @(negedge clk);
    chk_reg(3'd1, 32'h04, "R12", "BRKP and idle");
    dreq = 1'b1; repeat (8) @(negedge clk); dreq = 1'b0;
    repeat (4) @(negedge clk);
    chk(cyc_seen == 0, "R12", "no cycle after breakpoint", cyc_seen, 0);
    wr_reg(3'd1, 32'h04);
    chk_reg(3'd1, 32'h0, "R11", "clear BRKP");

    finish_run();
  end
endmodule